// File: doc/BRIEF.md
# Command-Queue SPI Master Sequencer

This block is an SPI master that executes a list of transfer commands stored in small internal memories. Software fills a transmit-data memory and a command memory through a shared write port. It then sets a start pointer and a last-entry pointer, and sets the run bit. The sequencer fetches each entry in turn and drives the chip-select lines from the command. It shifts out up to 16 bits, MSB first, in SPI mode 0, and stores the received word in a receive memory at the same index. It then advances to the next entry until the last entry is done.

In wrap mode the queue repeats from the start pointer until software halts it. A halt request never cuts a word short: it takes effect when the current word ends. Clearing the request resumes execution at the next entry. A loop test mode feeds the serial output back into the receiver in place of the MISO pin. A mode-fault detector aborts everything if the slave-select input is pulled low while the master is active. A single interrupt line reports halt-acknowledge and mode fault when software has enabled it.

Top module: `cmdq_spi_seq`

## Requirements
- R1: Setting the run bit (control bit 0, register 0) while idle starts execution at the entry held in the start pointer (register 1 bits [7:0]). Entries run in ascending index order up to the last-entry pointer (register 1 bits [15:8]). Each received word is stored at the same index of the receive memory.
- R2: The command word holds a continue bit at [15], a chip-select pattern at [7:4] and a length code at [3:0]. Code 0 means 16 bits, codes 1 to 7 mean 8 bits, and codes 8 to 15 mean that many bits. Exactly that many SCK rising edges occur, and the received word holds only the low length bits. The transmit word's low length bits are sent MSB first.
- R3: With wrap off (control bit 1 = 0), the sequencer stops after the last entry. It sets the queue-complete flag (status bit 2) and clears the run bit.
- R4: With wrap on, the entry after the last entry is the start-pointer entry, and execution repeats without setting queue-complete.
- R5: With loop mode on (control bit 2), the received data equals the transmitted data whatever MISO carries. SCK and MOSI behave exactly as with loop mode off.
- R6: Setting the halt bit (control bit 4) lets the current word finish. The sequencer then stops, sets halt-acknowledge (status bit 0), and produces no further SCK edges.
- R7: While halted, the chip-select outputs keep the pattern of the last command when its continue bit is 1. After a command whose continue bit is 0, they return to all ones.
- R8: Clearing the halt bit while halted resumes at the next queue entry. Status bits [15:8] show the index of the entry that runs next.
- R9: If ss_n is low while the sequencer is active, the transfer is aborted. Mode fault (status bit 1) is set, the run bit is cleared, cs_n goes to all ones and SCK stays low.
- R10: irq is 1 one cycle after (halt-acknowledge or mode fault) is set while the interrupt enable (control bit 3) is 1. With the enable at 0 the flags still set, but irq stays 0.
- R11: After reset all control bits, pointers and status flags are 0, cs_n is all ones, SCK is low and irq is 0.
- R12: Writing 1 to a status bit position in register 2 clears that flag. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 pointers, 2 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for reg_addr |
| ram_we | input | 1 | Queue memory write strobe |
| ram_sel | input | 1 | 0 selects transmit data, 1 selects command |
| ram_addr | input | AW | Queue memory write index |
| ram_wdata | input | 16 | Queue memory write data |
| rx_raddr | input | AW | Receive memory read index |
| rx_rdata | output | 16 | Registered receive memory read data |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select input for mode-fault detection |
| cs_n | output | CS_W | Peripheral chip selects |
| irq | output | 1 | Interrupt request |

## Verification
A halt request and the end of the queue can land on the same word boundary. Under this design's priority, completion of the last entry without wrap wins: queue-complete is set and halt-acknowledge stays clear. The bench provokes this by running a one-entry queue and raising the halt bit during that entry's first SCK pulse. It then reads the status register and checks that queue-complete is 1 and halt-acknowledge is 0. Halt arriving mid-word on a non-final entry is checked separately, by counting the SCK edges seen before acknowledge.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FETCH = 3'd1,
    S_LOAD  = 3'd2,
    S_SHIFT = 3'd3,
    S_HALT  = 3'd4
  } seq_state_t;

  localparam int CTL_RUN  = 0;
  localparam int CTL_WRAP = 1;
  localparam int CTL_LOOP = 2;
  localparam int CTL_IE   = 3;
  localparam int CTL_HALT = 4;

  // length code to bit count: 0 -> 16, 1..7 -> 8, 8..15 -> itself
  function automatic logic [4:0] word_len(input logic [3:0] code);
    if (code == 4'd0)      return 5'd16;
    else if (code < 4'd8)  return 5'd8;
    else                   return {1'b0, code};
  endfunction

endpackage

// File: rtl/cmdq_dpram.sv
module cmdq_dpram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cmdq_shifter.sv
module cmdq_shifter #(
  parameter int DIV = 2,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        abort,
  input  logic        loop_en,
  input  logic [15:0] tx_word,
  input  logic [4:0]  nbits,
  input  logic        miso,
  output logic        sck,
  output logic        mosi,
  output logic        done,
  output logic [15:0] rx_word
);

  logic [15:0]   sh_q;
  logic [4:0]    bit_q, len_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign mosi = sh_q[15];

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy_q  <= 1'b0;
      sck     <= 1'b0;
      done    <= 1'b0;
      sh_q    <= '0;
      rx_word <= '0;
      bit_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy_q) begin
        busy_q  <= 1'b1;
        sh_q    <= tx_word << (5'd16 - nbits);
        rx_word <= '0;
        bit_q   <= '0;
        len_q   <= nbits;
        cnt_q   <= '0;
        sck     <= 1'b0;
      end else if (busy_q) begin
        if (cnt_q == CW'(DIV - 1)) begin
          cnt_q <= '0;
          if (!sck) begin
            sck     <= 1'b1;
            rx_word <= {rx_word[14:0], loop_en ? sh_q[15] : miso};
          end else begin
            sck  <= 1'b0;
            sh_q <= sh_q << 1;
            if (bit_q == len_q - 5'd1) begin
              busy_q <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_q <= bit_q + 5'd1;
            end
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/cmdq_spi_seq.sv
module cmdq_spi_seq
  import cmdq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CS_W  = 4,
  parameter int DIV   = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [15:0]     reg_wdata,
  output logic [15:0]     reg_rdata,
  input  logic            ram_we,
  input  logic            ram_sel,
  input  logic [AW-1:0]   ram_addr,
  input  logic [15:0]     ram_wdata,
  input  logic [AW-1:0]   rx_raddr,
  output logic [15:0]     rx_rdata,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  input  logic            ss_n,
  output logic [CS_W-1:0] cs_n,
  output logic            irq
);

  localparam int PADW = 8 - AW;

  seq_state_t      state_q;
  logic [AW-1:0]   ptr_q, newq_q, endq_q;
  logic            ctrl_en, ctrl_wrap, ctrl_loop, ctrl_ie, ctrl_halt;
  logic            st_ha, st_mf, st_qc;
  logic            cont_q;
  logic [CS_W-1:0] pat_q;
  logic [15:0]     tx_q, cmd_q, rx_word;
  logic            sh_start, sh_done, fault, at_end, unused_bits;

  assign fault    = !ss_n && (state_q != S_IDLE);
  assign sh_start = (state_q == S_LOAD);
  assign at_end   = (ptr_q == endq_q);
  assign unused_bits = ^{reg_wdata, cmd_q};

  cmdq_dpram #(.W(16), .DEPTH(DEPTH)) u_txmem (
    .clk(clk), .we(ram_we && !ram_sel), .waddr(ram_addr), .wdata(ram_wdata),
    .raddr(ptr_q), .rdata(tx_q));

  cmdq_dpram #(.W(16), .DEPTH(DEPTH)) u_cmdmem (
    .clk(clk), .we(ram_we && ram_sel), .waddr(ram_addr), .wdata(ram_wdata),
    .raddr(ptr_q), .rdata(cmd_q));

  cmdq_dpram #(.W(16), .DEPTH(DEPTH)) u_rxmem (
    .clk(clk), .we(sh_done && !fault), .waddr(ptr_q), .wdata(rx_word),
    .raddr(rx_raddr), .rdata(rx_rdata));

  cmdq_shifter #(.DIV(DIV)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .abort(fault), .loop_en(ctrl_loop),
    .tx_word(tx_q), .nbits(word_len(cmd_q[3:0])), .miso(miso),
    .sck(sck), .mosi(mosi), .done(sh_done), .rx_word(rx_word));

  // register read mux, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        2'd0:    reg_rdata <= {11'd0, ctrl_halt, ctrl_ie, ctrl_loop, ctrl_wrap, ctrl_en};
        2'd1:    reg_rdata <= {{PADW{1'b0}}, endq_q, {PADW{1'b0}}, newq_q};
        2'd2:    reg_rdata <= {{PADW{1'b0}}, ptr_q, 5'd0, st_qc, st_mf, st_ha};
        default: reg_rdata <= '0;
      endcase
    end
  end

  // control, status and sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      ptr_q     <= '0;
      newq_q    <= '0;
      endq_q    <= '0;
      ctrl_en   <= 1'b0;
      ctrl_wrap <= 1'b0;
      ctrl_loop <= 1'b0;
      ctrl_ie   <= 1'b0;
      ctrl_halt <= 1'b0;
      st_ha     <= 1'b0;
      st_mf     <= 1'b0;
      st_qc     <= 1'b0;
      cont_q    <= 1'b0;
      pat_q     <= '1;
      cs_n      <= '1;
      irq       <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          2'd0: begin
            ctrl_en   <= reg_wdata[CTL_RUN];
            ctrl_wrap <= reg_wdata[CTL_WRAP];
            ctrl_loop <= reg_wdata[CTL_LOOP];
            ctrl_ie   <= reg_wdata[CTL_IE];
            ctrl_halt <= reg_wdata[CTL_HALT];
          end
          2'd1: begin
            newq_q <= reg_wdata[AW-1:0];
            endq_q <= reg_wdata[8+AW-1:8];
          end
          2'd2: begin
            if (reg_wdata[0]) st_ha <= 1'b0;
            if (reg_wdata[1]) st_mf <= 1'b0;
            if (reg_wdata[2]) st_qc <= 1'b0;
          end
          default: ;
        endcase
      end

      irq <= ctrl_ie && (st_ha || st_mf);

      if (fault) begin
        state_q <= S_IDLE;
        ctrl_en <= 1'b0;
        st_mf   <= 1'b1;
        cs_n    <= '1;
      end else begin
        case (state_q)
          S_IDLE: begin
            if (ctrl_en) begin
              ptr_q   <= newq_q;
              state_q <= S_FETCH;
            end
          end
          S_FETCH: state_q <= S_LOAD;
          S_LOAD: begin
            cs_n    <= cmd_q[CS_W+3:4];
            pat_q   <= cmd_q[CS_W+3:4];
            cont_q  <= cmd_q[15];
            state_q <= S_SHIFT;
          end
          S_SHIFT: begin
            if (sh_done) begin
              cs_n <= cont_q ? pat_q : '1;
              if (at_end && !ctrl_wrap) begin
                state_q <= S_IDLE;
                st_qc   <= 1'b1;
                ctrl_en <= 1'b0;
              end else begin
                ptr_q <= at_end ? newq_q : ptr_q + AW'(1);
                if (ctrl_halt) begin
                  state_q <= S_HALT;
                  st_ha   <= 1'b1;
                end else begin
                  state_q <= S_FETCH;
                end
              end
            end
          end
          S_HALT: begin
            if (!ctrl_halt) state_q <= S_FETCH;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cmdq_spi_seq_chk.sv
module cmdq_spi_seq_chk
  import cmdq_pkg::*;
#(
  parameter int CS_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            sck,
  input logic [CS_W-1:0] cs_n,
  input logic            irq,
  input logic            ctrl_ie,
  input logic            ctrl_en,
  input logic            st_ha,
  input logic            st_mf,
  input logic            st_qc,
  input logic [2:0]      st,
  input logic            sh_done
);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctrl_ie)) else $error("irq without enable"); // R10

  AST_SCK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE || st == S_HALT) |-> !sck) else $error("sck active while stopped"); // R6

  AST_HALT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(st_ha) |-> $past(sh_done)) else $error("halt not on word boundary"); // R6

  AST_HALT_CS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (st == S_HALT && $past(st == S_HALT)) |-> $stable(cs_n)) else $error("cs moved while halted"); // R7

  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (rst)
    $rose(st_mf) |-> (!ctrl_en && st == S_IDLE && cs_n == '1)) else $error("fault did not stop"); // R9

  AST_COMPLETE_STOPS: assert property (@(posedge clk) disable iff (rst)
    $rose(st_qc) |-> (!ctrl_en && st == S_IDLE)) else $error("complete without stop"); // R3

endmodule

bind cmdq_spi_seq cmdq_spi_seq_chk #(.CS_W(CS_W)) u_chk (
  .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .irq(irq),
  .ctrl_ie(ctrl_ie), .ctrl_en(ctrl_en), .st_ha(st_ha), .st_mf(st_mf),
  .st_qc(st_qc), .st(state_q), .sh_done(sh_done));

// File: tb/test_cmdq_spi_seq.sv
module test_cmdq_spi_seq;

  localparam int DEPTH = 16;
  localparam int CS_W  = 4;
  localparam int AW    = 4;
  localparam int NV    = 12;

  // {tx[15:0], len code[3:0], continue, cs pattern[3:0]}
  localparam logic [24:0] VEC [NV] = '{
    {16'hA5C3, 4'd0,  1'b1, 4'b1110},
    {16'h1234, 4'd8,  1'b0, 4'b1101},
    {16'h00F0, 4'd1,  1'b1, 4'b1011},
    {16'hBEEF, 4'd15, 1'b0, 4'b0111},
    {16'h0F0F, 4'd12, 1'b1, 4'b1100},
    {16'h8001, 4'd10, 1'b0, 4'b1110},
    {16'h3C3C, 4'd12, 1'b1, 4'b1010},
    {16'h5A5A, 4'd12, 1'b0, 4'b0101},
    {16'h7777, 4'd12, 1'b1, 4'b0011},
    {16'h0FED, 4'd12, 1'b0, 4'b1001},
    {16'h00AA, 4'd8,  1'b0, 4'b1110},
    {16'hFFFF, 4'd9,  1'b0, 4'b0110}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic ram_we = 1'b0, ram_sel = 1'b0;
  logic [AW-1:0] ram_addr = '0, rx_raddr = '0;
  logic [15:0] ram_wdata = '0, rx_rdata;
  logic sck, mosi, miso, ss_n = 1'b1, irq;
  logic [CS_W-1:0] cs_n;

  int errors = 0, checks = 0;
  int edges = 0, ones = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign miso = ~mosi;

  always @(posedge sck) begin
    edges <= edges + 1;
    if (mosi) ones <= ones + 1;
  end

  cmdq_spi_seq #(.DEPTH(DEPTH), .CS_W(CS_W), .DIV(2)) i_cmdq_spi_seq (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ram_we(ram_we),
    .ram_sel(ram_sel), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .rx_raddr(rx_raddr), .rx_rdata(rx_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n(ss_n), .cs_n(cs_n), .irq(irq));

  function automatic int blen(input logic [3:0] c);
    if (c == 0) return 16;
    if (c < 8) return 8;
    return int'(c);
  endfunction

  function automatic logic [15:0] exp_rx(input int i, input bit lp);
    logic [15:0] tx, m;
    int n;
    tx = VEC[i][24:9];
    n  = blen(VEC[i][8:5]);
    m  = (n == 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    return (lp ? tx : ~tx) & m;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd_rx(input int i, output logic [15:0] d);
    @(negedge clk);
    rx_raddr = AW'(i);
    @(negedge clk);
    d = rx_rdata;
  endtask

  task automatic wait_flag(input int b, input string tag);
    logic [15:0] s;
    bit seen = 0;
    for (int k = 0; k < 4000 && !seen; k++) begin
      rd(2'd2, s);
      seen = s[b];
    end
    check(tag, 32'(seen), 32'd1);
  endtask

  task automatic check_rx(input int lo, input int hi, input bit lp, input string tag);
    logic [15:0] d;
    for (int i = lo; i <= hi; i++) begin
      rd_rx(i, d);
      check(tag, 32'(d), 32'(exp_rx(i, lp)));
    end
  endtask

  task automatic wait_edges(input int target);
    for (int k = 0; k < 4000 && edges < target; k++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int e0, o0, sum;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check("R11 cs_n", 32'(cs_n), 32'hF);
    check("R11 sck", 32'(sck), 0);
    check("R11 irq", 32'(irq), 0);
    rd(2'd0, d); check("R11 ctrl", 32'(d), 0);
    rd(2'd2, d); check("R11 status", 32'(d), 0);

    // load queue memories from the vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ram_we = 1'b1; ram_sel = 1'b0; ram_addr = AW'(i); ram_wdata = VEC[i][24:9];
      @(negedge clk);
      ram_sel = 1'b1;
      ram_wdata = {VEC[i][4], 7'd0, VEC[i][3:0], VEC[i][8:5]};
    end
    @(negedge clk); ram_we = 1'b0;

    // R1 R2 R3 single pass over entries 2..5
    sum = 0;
    for (int i = 2; i <= 5; i++) sum += blen(VEC[i][8:5]);
    wr(2'd1, 16'h0502);
    e0 = edges; o0 = ones;
    wr(2'd0, 16'h0001);
    wait_flag(2, "R3 complete flag");
    check_rx(2, 5, 1'b0, "R1 R2 rx word");
    check("R2 sck edges", 32'(edges - e0), 32'(sum));
    rd(2'd0, d); check("R3 run cleared", 32'(d[0]), 0);
    check("R7 cs after cont=0", 32'(cs_n), 32'hF);
    o0 = ones - o0;
    wr(2'd2, 16'h0004);
    rd(2'd2, d); check("R12 clear complete", 32'(d[2:0]), 0);

    // R5 loop mode
    e0 = edges;
    sum = ones;
    wr(2'd0, 16'h0005);
    wait_flag(2, "R5 complete");
    check_rx(2, 5, 1'b1, "R5 loop rx");
    check("R5 sck same", 32'(edges - e0), 32'(blen(VEC[2][8:5]) + blen(VEC[3][8:5]) + blen(VEC[4][8:5]) + blen(VEC[5][8:5])));
    check("R5 mosi same", 32'(ones - sum), 32'(o0));
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0007);

    // R4 wraparound over 0..1
    wr(2'd1, 16'h0100);
    e0 = edges;
    wr(2'd0, 16'h0003);
    wait_edges(e0 + 60);
    wr(2'd0, 16'h0013);
    wait_flag(0, "R4 halt ack");
    rd(2'd2, d); check("R4 no complete", 32'(d[2]), 0);
    check("R4 repeated", 32'(edges - e0 > 48), 1);
    check_rx(0, 1, 1'b0, "R4 rx");
    wr(2'd0, 16'h0000);
    wait_flag(2, "R4 drain complete");
    wr(2'd2, 16'h0007);

    // R6 R7 R8 halt in mid-word on 6..9
    wr(2'd1, 16'h0906);
    e0 = edges;
    wr(2'd0, 16'h0001);
    wait_edges(e0 + 1);
    wr(2'd0, 16'h0011);
    wait_flag(0, "R6 halt ack");
    check("R6 word finished", 32'(edges - e0), 12);
    rd(2'd2, d); check("R8 next index", 32'(d[15:8]), 7);
    check("R7 cs held", 32'(cs_n), 32'b1010);
    check("R10 irq gated", 32'(irq), 0);
    repeat (100) @(negedge clk);
    check("R6 no sck while halted", 32'(edges - e0), 12);
    wr(2'd0, 16'h0019);
    repeat (2) @(negedge clk);
    check("R10 irq on halt", 32'(irq), 1);
    wr(2'd0, 16'h0001);
    wait_flag(2, "R8 resumed complete");
    check("R8 resume edges", 32'(edges - e0), 48);
    check_rx(6, 9, 1'b0, "R8 rx");
    wr(2'd2, 16'h0007);

    // halt raised during the last entry: completion wins
    wr(2'd1, 16'h0A0A);
    e0 = edges;
    wr(2'd0, 16'h0001);
    wait_edges(e0 + 1);
    wr(2'd0, 16'h0011);
    wait_flag(2, "R3 complete with halt");
    rd(2'd2, d); check("R6 no ack at end", 32'(d[0]), 0);
    check_rx(10, 10, 1'b0, "R1 rx single");
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0007);

    // R9 mode fault
    wr(2'd1, 16'h0502);
    e0 = edges;
    wr(2'd0, 16'h0001);
    wait_edges(e0 + 3);
    @(negedge clk); ss_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 sck low", 32'(sck), 0);
    check("R9 cs released", 32'(cs_n), 32'hF);
    ss_n = 1'b1;
    e0 = edges;
    rd(2'd2, d); check("R9 fault flag", 32'(d[1]), 1);
    rd(2'd0, d); check("R9 run cleared", 32'(d[0]), 0);
    check("R10 irq gated fault", 32'(irq), 0);
    repeat (50) @(negedge clk);
    check("R9 stays stopped", 32'(edges - e0), 0);
    wr(2'd0, 16'h0008);
    repeat (2) @(negedge clk);
    check("R10 irq on fault", 32'(irq), 1);
    wr(2'd2, 16'h0002);
    repeat (2) @(negedge clk);
    check("R12 irq after clear", 32'(irq), 0);
    rd(2'd2, d); check("R12 fault cleared", 32'(d[1:0]), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule